// File: doc/BRIEF.md
# JTAG Master Shift Engine

This block is the host end of a JTAG link. It produces TCK, TMS and TDI for one target TAP and captures TDO. It runs one command at a time, each taken through a valid/ready handshake. A shift command moves up to 32 bits through the Shift-IR or Shift-DR state. It sends them low bit first or high bit first, and it places the captured bits in the same order. Three navigation commands are provided. One goes from Run-Test/Idle to Shift-IR, one goes to Shift-DR, and one resets the TAP, ending in Run-Test/Idle. When a command finishes, the block gives a one-cycle done strobe together with the captured word.

A transfer longer than 32 bits is built from several shift commands. All but the last have the exit flag clear, so the TAP stays in its shift state between them. On the last bit the exit flag raises TMS. After that the engine either walks on through Update to Run-Test/Idle, or it stops in Update. Stopping in Update lets the next Shift-DR navigation pass straight from Update to Select-DR without ever reaching Run-Test/Idle. The TCK rate comes from a half-period divider input.

The control is a single state machine with these states:
- ST_IDLE: ready for a command.
- ST_WALK_LO and ST_WALK_HI: the two halves of a TCK pulse whose TMS comes from a pattern register.
- ST_BIT_LO and ST_BIT_HI: the two halves of a data-bit pulse.
- ST_FINISH: the done cycle.

Its transitions are:
- accept-shift: ST_IDLE to ST_BIT_LO.
- accept-walk: ST_IDLE to ST_WALK_LO, for any navigation command.
- rise: LO to HI when the half-period expires.
- next-walk: ST_WALK_HI to ST_WALK_LO while pattern pulses remain.
- walk-done: ST_WALK_HI to ST_FINISH.
- next-bit: ST_BIT_HI to ST_BIT_LO.
- exit-walk: ST_BIT_HI to ST_WALK_LO on the last bit when the exit flag is set.
- shift-done: ST_BIT_HI to ST_FINISH on the last bit when the exit flag is clear.
- release: ST_FINISH to ST_IDLE.

Top module: `jtag_shift_master`

## Requirements
- R1: cmd_ready is high only in idle. A command is taken on a clock edge where cmd_valid and cmd_ready are both high. cmd_ready is low in the next cycle and stays low until the cycle after done.
- R2: TCK is low whenever the engine is idle. While a command runs, each high phase and each low phase of TCK lasts half_div+1 clock cycles.
- R3: TMS and TDI change only at the moment TCK falls (or before the first rise), and hold steady while TCK is high. TDO is sampled in the last clock cycle of each TCK high phase of a data bit.
- R4: cmd_op=3 (TAP reset) gives five TCK pulses with TMS high, then one pulse with TMS low, leaving the TAP in Run-Test/Idle. rsp_word is 0.
- R5: cmd_op=1 gives four pulses with TMS 1,1,0,0, moving a TAP from Run-Test/Idle to Shift-IR. rsp_word is 0.
- R6: cmd_op=2 gives three pulses with TMS 1,0,0, moving a TAP from Run-Test/Idle or from Update-DR/IR to Shift-DR.
- R7: cmd_op=0 shifts cmd_len+1 bits (cmd_len is 0..31). When cmd_msb_first is 0, TDI carries cmd_word bit 0 first, and the k-th captured TDO bit goes to rsp_word bit k. rsp_word bits at or above the count are 0.
- R8: When cmd_msb_first is 1, TDI carries cmd_word bit cmd_len first, then counts downward. The k-th captured bit goes to rsp_word bit cmd_len-k.
- R9: When cmd_exit is 0, TMS is low on every data bit and no further pulse follows, so the TAP stays in its shift state. cmd_ret_idle has no effect in that case.
- R10: When cmd_exit is 1, TMS is high on the last data bit. One pulse with TMS high (to Update) follows. If cmd_ret_idle is 1, a final pulse with TMS low (to Run-Test/Idle) comes after it; otherwise the engine stops in Update.
- R11: done is high for exactly one cycle, after the final TCK fall, with TCK low. rsp_word holds the captured word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | TCK half-period is half_div+1 clocks; keep steady while busy |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 0 shift, 1 go to Shift-IR, 2 go to Shift-DR, 3 TAP reset |
| cmd_word | input | DATA_W | Bits to send on TDI |
| cmd_len | input | LEN_W | Bit count minus one |
| cmd_msb_first | input | 1 | 1 sends bit cmd_len first, 0 sends bit 0 first |
| cmd_exit | input | 1 | Raise TMS on the last bit and walk to Update |
| cmd_ret_idle | input | 1 | After Update, continue to Run-Test/Idle |
| done | output | 1 | One-cycle completion strobe |
| rsp_word | output | DATA_W | Captured TDO bits |
| tck | output | 1 | JTAG clock, idles low |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to target |
| tdo | input | 1 | JTAG data from target |

## Verification
The bench puts a behavioural TAP against the engine. This TAP follows all sixteen controller states, logs every TMS and TDI value at TCK rise, and drives a position-dependent TDO pattern at TCK fall. Each command is therefore judged by where the TAP ends up, by the TMS sequence, and by the order of bits on TDI and in the captured word.

The data word is asymmetric, so a swap of bit order or an off-by-one in the count shows up at once. A 32-bit high-bit-first shift, a 4-bit low-bit-first shift, a 1-bit shift and a pair of chained 8-bit shifts separate the order, the count and the exit handling. A Shift-DR navigation issued from Update-DR, with a count of Run-Test/Idle visits, shows that the stop-in-Update path works. Two divider settings separate a fixed TCK width from a programmed one.

// File: rtl/jtsm_pkg.sv
package jtsm_pkg;

    // Command codes, as seen on cmd_op
    typedef enum logic [1:0] {
        OP_SHIFT     = 2'd0,
        OP_GOTO_IR   = 2'd1,
        OP_GOTO_DR   = 2'd2,
        OP_TAP_RESET = 2'd3
    } jtsm_op_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WALK_LO = 3'd1,
        ST_WALK_HI = 3'd2,
        ST_BIT_LO  = 3'd3,
        ST_BIT_HI  = 3'd4,
        ST_FINISH  = 3'd5
    } jtsm_state_e;

endpackage

// File: rtl/jtsm_half_timer.sv
// Counts one TCK half-period while a pulse is in progress.
module jtsm_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             expire
);
    logic [DIV_W-1:0] cnt_q;

    assign expire = run && (cnt_q >= half_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // Timer is always restarted from zero when a phase ends (R2)
    assert_phase_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && expire) |=> (cnt_q == '0));

endmodule

// File: rtl/jtsm_bit_pos.sv
// Maps the running bit index to a word position for the chosen order.
module jtsm_bit_pos #(
    parameter int DATA_W = 32,
    localparam int LEN_W = $clog2(DATA_W)
) (
    input  logic             active,
    input  logic             msb_first,
    input  logic [LEN_W-1:0] idx,
    input  logic [LEN_W-1:0] last_idx,
    output logic [LEN_W-1:0] pos,
    output logic             is_last
);
    assign pos     = msb_first ? (last_idx - idx) : idx;
    assign is_last = (idx == last_idx);

    always_comb begin
        if (active === 1'b1) begin
            assert_index_in_range_R7: assert (idx <= last_idx);
        end
    end

endmodule

// File: rtl/jtsm_tms_pattern.sv
// TMS walk patterns, sent from bit 0 upward, one bit per TCK pulse.
module jtsm_tms_pattern #(
    parameter int RESET_PULSES = 5,
    localparam int PAT_W  = RESET_PULSES + 1,
    localparam int PCNT_W = $clog2(PAT_W + 1)
) (
    input  jtsm_pkg::jtsm_op_e op,
    input  logic               ret_idle,
    output logic [PAT_W-1:0]   nav_pat,
    output logic [PCNT_W-1:0]  nav_cnt,
    output logic [PAT_W-1:0]   post_pat,
    output logic [PCNT_W-1:0]  post_cnt
);
    import jtsm_pkg::*;

    logic [PAT_W-1:0] reset_pat;

    // RESET_PULSES ones, then a single zero
    always_comb begin
        reset_pat = '0;
        for (int i = 0; i < RESET_PULSES; i++) begin
            reset_pat[i] = 1'b1;
        end
    end

    always_comb begin
        nav_pat = '0;
        nav_cnt = '0;
        unique case (op)
            OP_GOTO_IR: begin
                nav_pat = PAT_W'(4'b0011);   // 1,1,0,0
                nav_cnt = PCNT_W'(4);
            end
            OP_GOTO_DR: begin
                nav_pat = PAT_W'(3'b001);    // 1,0,0
                nav_cnt = PCNT_W'(3);
            end
            OP_TAP_RESET: begin
                nav_pat = reset_pat;
                nav_cnt = PCNT_W'(PAT_W);
            end
            default: begin
                nav_pat = '0;
                nav_cnt = '0;
            end
        endcase
    end

    // After the exit bit: 1 to Update, then optionally 0 to Run-Test/Idle
    assign post_pat = PAT_W'(2'b01);
    assign post_cnt = ret_idle ? PCNT_W'(2) : PCNT_W'(1);

endmodule

// File: rtl/jtag_shift_master.sv
module jtag_shift_master #(
    parameter int DATA_W       = 32,
    parameter int DIV_W        = 8,
    parameter int RESET_PULSES = 5,
    localparam int LEN_W  = $clog2(DATA_W),
    localparam int PAT_W  = RESET_PULSES + 1,
    localparam int PCNT_W = $clog2(PAT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_word,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_msb_first,
    input  logic              cmd_exit,
    input  logic              cmd_ret_idle,
    output logic              done,
    output logic [DATA_W-1:0] rsp_word,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    input  logic              tdo
);
    import jtsm_pkg::*;

    jtsm_state_e       state_q, state_d;
    logic [DATA_W-1:0] data_q, cap_q;
    logic [LEN_W-1:0]  last_q, idx_q, pos;
    logic              msb_q, exit_q, ret_q;
    logic [PAT_W-1:0]  pat_q, nav_pat, post_pat;
    logic [PCNT_W-1:0] pcnt_q, nav_cnt, post_cnt;
    logic              expire, run, is_last, accept, in_bits, in_walk;
    jtsm_op_e          op_in;

    assign op_in   = jtsm_op_e'(cmd_op);
    assign accept  = cmd_valid && (state_q == ST_IDLE);
    assign in_bits = (state_q == ST_BIT_LO) || (state_q == ST_BIT_HI);
    assign in_walk = (state_q == ST_WALK_LO) || (state_q == ST_WALK_HI);
    assign run     = in_bits || in_walk;

    jtsm_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_div (half_div),
        .expire   (expire)
    );

    jtsm_bit_pos #(.DATA_W(DATA_W)) u_pos (
        .active    (in_bits),
        .msb_first (msb_q),
        .idx       (idx_q),
        .last_idx  (last_q),
        .pos       (pos),
        .is_last   (is_last)
    );

    jtsm_tms_pattern #(.RESET_PULSES(RESET_PULSES)) u_pat (
        .op       (op_in),
        .ret_idle (cmd_ret_idle),
        .nav_pat  (nav_pat),
        .nav_cnt  (nav_cnt),
        .post_pat (post_pat),
        .post_cnt (post_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cmd_valid) state_d = (op_in == OP_SHIFT) ? ST_BIT_LO : ST_WALK_LO;
            ST_WALK_LO: if (expire) state_d = ST_WALK_HI;
            ST_WALK_HI: if (expire) state_d = (pcnt_q == PCNT_W'(1)) ? ST_FINISH : ST_WALK_LO;
            ST_BIT_LO:  if (expire) state_d = ST_BIT_HI;
            ST_BIT_HI:  if (expire) begin
                            if (!is_last)    state_d = ST_BIT_LO;
                            else if (exit_q) state_d = ST_WALK_LO;
                            else             state_d = ST_FINISH;
                        end
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Datapath: command capture, pattern walk, bit shift and TDO capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            cap_q  <= '0;
            last_q <= '0;
            idx_q  <= '0;
            msb_q  <= 1'b0;
            exit_q <= 1'b0;
            ret_q  <= 1'b0;
            pat_q  <= '0;
            pcnt_q <= '0;
        end else if (accept) begin
            data_q <= cmd_word;
            cap_q  <= '0;
            last_q <= cmd_len;
            idx_q  <= '0;
            msb_q  <= cmd_msb_first;
            exit_q <= cmd_exit;
            ret_q  <= cmd_ret_idle;
            pat_q  <= nav_pat;
            pcnt_q <= nav_cnt;
        end else if (expire && (state_q == ST_WALK_HI)) begin
            pat_q  <= pat_q >> 1;
            pcnt_q <= pcnt_q - PCNT_W'(1);
        end else if (expire && (state_q == ST_BIT_HI)) begin
            cap_q[pos] <= tdo;
            idx_q      <= idx_q + LEN_W'(1);
            if (is_last && exit_q) begin
                pat_q  <= post_pat;
                pcnt_q <= ret_q ? PCNT_W'(2) : PCNT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        tck       = (state_q == ST_WALK_HI) || (state_q == ST_BIT_HI);
        tms       = 1'b0;
        tdi       = 1'b0;
        cmd_ready = (state_q == ST_IDLE);
        done      = (state_q == ST_FINISH);
        rsp_word  = cap_q;
        unique case (state_q)
            ST_WALK_LO, ST_WALK_HI: tms = pat_q[0];
            ST_BIT_LO,  ST_BIT_HI: begin
                tms = exit_q && is_last;
                tdi = data_q[pos];
            end
            default: ;
        endcase
    end

    // Pins are frozen for the whole high phase (R3)
    assert_pins_hold_while_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));

    // Accepting a command drops ready at once (R1)
    assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // Done is a single pulse followed by ready (R11)
    assert_done_then_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cmd_ready && !done));

    // Done only follows the last TCK fall (R11)
    assert_done_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!tck && $past(!cmd_ready)));

    // A walk never starts with an empty pattern (R4)
    assert_walk_has_pulses_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_walk |-> (pcnt_q != '0));

    // Without the exit flag TMS stays low through the data bits (R9)
    assert_no_exit_tms_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_bits && !exit_q) |-> !tms);

endmodule

// File: tb/test_jtag_shift_master.sv
module test_jtag_shift_master;
    import jtsm_pkg::*;

    localparam int DATA_W = 32;
    localparam int DIV_W  = 8;
    localparam int LEN_W  = 5;

    typedef enum logic [3:0] {
        TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_e;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  half_div = '0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [1:0]        cmd_op = '0;
    logic [DATA_W-1:0] cmd_word = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic              cmd_msb_first = 1'b0;
    logic              cmd_exit = 1'b0;
    logic              cmd_ret_idle = 1'b0;
    logic              done;
    logic [DATA_W-1:0] rsp_word;
    logic              tck, tms, tdi;
    logic              tdo = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    jtag_shift_master i_jtag_shift_master (
        .clk(clk), .rst_n(rst_n), .half_div(half_div),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_word(cmd_word), .cmd_len(cmd_len), .cmd_msb_first(cmd_msb_first),
        .cmd_exit(cmd_exit), .cmd_ret_idle(cmd_ret_idle),
        .done(done), .rsp_word(rsp_word),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    // ---------------- behavioural target TAP ----------------
    tap_e tap = UPD_IR;
    bit   tms_log [0:1023];
    bit   tdi_log [0:1023];
    int   tms_n = 0, tdi_n = 0, tdo_k = 0, rti_visits = 0;

    function automatic tap_e tap_next(tap_e s, logic m);
        case (s)
            TLR:    return m ? TLR    : RTI;
            RTI:    return m ? SEL_DR : RTI;
            SEL_DR: return m ? SEL_IR : CAP_DR;
            CAP_DR: return m ? EX1_DR : SH_DR;
            SH_DR:  return m ? EX1_DR : SH_DR;
            EX1_DR: return m ? UPD_DR : PAU_DR;
            PAU_DR: return m ? EX2_DR : PAU_DR;
            EX2_DR: return m ? UPD_DR : SH_DR;
            UPD_DR: return m ? SEL_DR : RTI;
            SEL_IR: return m ? TLR    : CAP_IR;
            CAP_IR: return m ? EX1_IR : SH_IR;
            SH_IR:  return m ? EX1_IR : SH_IR;
            EX1_IR: return m ? UPD_IR : PAU_IR;
            PAU_IR: return m ? EX2_IR : PAU_IR;
            EX2_IR: return m ? UPD_IR : SH_IR;
            default: return m ? SEL_DR : RTI;   // UPD_IR
        endcase
    endfunction

    function automatic logic src_bit(int k);
        return logic'(((k * 13 + 5) % 7) > 2);
    endfunction

    always @(posedge tck) begin
        tms_log[tms_n] = tms;
        tms_n++;
        if (tap == SH_DR || tap == SH_IR) begin
            tdi_log[tdi_n] = tdi;
            tdi_n++;
        end
        tap = tap_next(tap, tms);
        if (tap == RTI) rti_visits++;
    end

    always @(negedge tck) begin
        if (tap == SH_DR || tap == SH_IR) begin
            tdo = src_bit(tdo_k);
            tdo_k++;
        end
    end

    // ---------------- phase-width and pin-stability monitors ----------------
    int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0, pin_moves = 0;
    logic prev_tck = 1'b0, prev_tms = 1'b0, prev_tdi = 1'b0;

    always @(negedge clk) begin
        if (tck) begin
            hi_run++;
            if (lo_run > 0) last_lo = lo_run;
            lo_run = 0;
            if (prev_tck && (tms !== prev_tms || tdi !== prev_tdi)) pin_moves++;
        end else begin
            if (hi_run > 0) last_hi = hi_run;
            hi_run = 0;
            if (cmd_ready) lo_run = 0;
            else           lo_run++;
        end
        prev_tck = tck;
        prev_tms = tms;
        prev_tdi = tdi;
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [31:0] word,
                           input logic [4:0] lenm1, input logic msb,
                           input logic ex, input logic ret,
                           output logic [31:0] rsp);
        int pulses;
        int guard;
        @(negedge clk);
        cmd_op = op; cmd_word = word; cmd_len = lenm1;
        cmd_msb_first = msb; cmd_exit = ex; cmd_ret_idle = ret;
        cmd_valid = 1'b1;
        guard = 0;
        while (!cmd_ready && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R1", "ready after accept", 32'(cmd_ready), 0);
        pulses = 0;
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        rsp = rsp_word;
        check(done && !tck, "R11", "done with tck low", {30'd0, done, tck}, 32'h2);
        @(negedge clk);
        check(!done && cmd_ready, "R11", "single done then ready",
              {30'd0, done, cmd_ready}, 32'h1);
    endtask

    task automatic check_tms(input int n0, input int cnt, input logic [31:0] exp,
                             input string req);
        logic [31:0] got = '0;
        check(tms_n - n0 == cnt, req, "tms pulse count", 32'(tms_n - n0), 32'(cnt));
        for (int i = 0; i < cnt; i++) got[i] = tms_log[n0 + i];
        check(got == exp, req, "tms sequence", got, exp);
    endtask

    // sends and captures a shift, checks TDI order and captured word
    task automatic do_shift(input logic [31:0] word, input int len, input logic msb,
                            input logic ex, input logic ret, input string req);
        int n0, k0;
        logic [31:0] rsp, exp_cap, got_tdi, exp_tdi;
        n0 = tdi_n;
        k0 = tdo_k - 1;
        run_cmd(2'd0, word, 5'(len - 1), msb, ex, ret, rsp);
        exp_cap = '0; got_tdi = '0; exp_tdi = '0;
        for (int i = 0; i < len; i++) begin
            got_tdi[i] = tdi_log[n0 + i];
            exp_tdi[i] = msb ? word[len - 1 - i] : word[i];
            if (msb) exp_cap[len - 1 - i] = src_bit(k0 + i);
            else     exp_cap[i]           = src_bit(k0 + i);
        end
        check(tdi_n - n0 == len, req, "bits shifted", 32'(tdi_n - n0), 32'(len));
        check(got_tdi == exp_tdi, req, "tdi order", got_tdi, exp_tdi);
        check(rsp == exp_cap, req, "captured word", rsp, exp_cap);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_values;
        check(cmd_ready == 1'b1, "R1", "ready after reset", 32'(cmd_ready), 1);
        check(tck == 1'b0 && done == 1'b0, "R2", "tck/done after reset",
              {30'd0, tck, done}, 0);
    endtask

    task automatic t_tap_reset;
        int n0;
        logic [31:0] rsp;
        half_div = 8'd2;
        n0 = tms_n;
        run_cmd(2'd3, 32'hFFFF_FFFF, 5'd0, 1'b0, 1'b0, 1'b0, rsp);
        check_tms(n0, 6, 32'h1F, "R4");
        check(tap == RTI, "R4", "tap state after reset", 32'(tap), 32'(RTI));
        check(rsp == 0, "R4", "response of reset", rsp, 0);
        check(last_hi == 3, "R2", "high phase width div=2", 32'(last_hi), 3);
        check(last_lo == 3, "R2", "low phase width div=2", 32'(last_lo), 3);
    endtask

    task automatic t_goto_ir;
        int n0;
        logic [31:0] rsp;
        half_div = 8'd0;
        n0 = tms_n;
        run_cmd(2'd1, 32'hFFFF_FFFF, 5'd7, 1'b0, 1'b1, 1'b1, rsp);
        check_tms(n0, 4, 32'h3, "R5");
        check(tap == SH_IR, "R5", "tap at Shift-IR", 32'(tap), 32'(SH_IR));
        check(rsp == 0, "R5", "response of goto", rsp, 0);
        check(last_hi == 1 && last_lo == 1, "R2", "phase widths div=0",
              32'(last_hi * 16 + last_lo), 32'h11);
    endtask

    task automatic t_shift_ir_lsb;
        int n0;
        half_div = 8'd1;
        n0 = tms_n;
        do_shift(32'h0000_000A, 4, 1'b0, 1'b1, 1'b1, "R7");
        check_tms(n0, 6, 32'h18, "R10");   // 0,0,0,1,1,0
        check(tap == RTI, "R10", "return to idle", 32'(tap), 32'(RTI));
        check(pin_moves == 0, "R3", "tms/tdi moved while tck high", 32'(pin_moves), 0);
    endtask

    task automatic t_goto_dr;
        int n0;
        logic [31:0] rsp;
        n0 = tms_n;
        run_cmd(2'd2, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, rsp);
        check_tms(n0, 3, 32'h1, "R6");
        check(tap == SH_DR, "R6", "tap at Shift-DR", 32'(tap), 32'(SH_DR));
    endtask

    task automatic t_shift_dr_msb;
        int n0;
        half_div = 8'd3;
        n0 = tms_n;
        do_shift(32'h8E3C_5A21, 32, 1'b1, 1'b1, 1'b0, "R8");
        check(tms_n - n0 == 33, "R10", "pulses without idle", 32'(tms_n - n0), 33);
        check(tms_log[n0 + 30] == 1'b0 && tms_log[n0 + 31] == 1'b1 && tms_log[n0 + 32] == 1'b1,
              "R10", "exit tms on last bit", 32'({tms_log[n0+30], tms_log[n0+31], tms_log[n0+32]}), 3);
        check(tap == UPD_DR, "R10", "stop in Update", 32'(tap), 32'(UPD_DR));
        check(last_hi == 4, "R2", "high phase width div=3", 32'(last_hi), 4);
    endtask

    task automatic t_direct_dr;
        int v0;
        logic [31:0] rsp;
        v0 = rti_visits;
        half_div = 8'd0;
        run_cmd(2'd2, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, rsp);
        check(tap == SH_DR, "R6", "Update to Shift-DR", 32'(tap), 32'(SH_DR));
        check(rti_visits == v0, "R10", "idle not visited", 32'(rti_visits - v0), 0);
    endtask

    task automatic t_chain;
        int n0;
        n0 = tms_n;
        do_shift(32'h0000_00C5, 8, 1'b0, 1'b0, 1'b1, "R9");
        check_tms(n0, 8, 32'h0, "R9");
        check(tap == SH_DR, "R9", "stays in Shift-DR", 32'(tap), 32'(SH_DR));
        do_shift(32'h0000_003B, 8, 1'b0, 1'b1, 1'b1, "R9");
        check(tap == RTI, "R9", "chain end in idle", 32'(tap), 32'(RTI));
    endtask

    task automatic t_single_bit;
        logic [31:0] rsp;
        run_cmd(2'd2, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, rsp);
        do_shift(32'hFFFF_FFFF, 1, 1'b1, 1'b1, 1'b1, "R8");
        check(tap == RTI, "R7", "one-bit shift ends idle", 32'(tap), 32'(RTI));
        check(pin_moves == 0, "R3", "tms/tdi moved while tck high", 32'(pin_moves), 0);
    endtask

    // ---------------- sequence and watchdog ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_values();
        t_tap_reset();
        t_goto_ir();
        t_shift_ir_lsb();
        t_goto_dr();
        t_shift_dr_msb();
        t_direct_dr();
        t_chain();
        t_single_bit();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule